// File: doc/BRIEF.md
# Burst Power Ramp Profile Sequencer

This block produces the control waveform for one transmit burst of an RF power amplifier. The waveform is a stream of 10-bit DAC codes at about 2 mV per code. The block also drives the enable line of the analog power controller. A trigger starts the burst. The enable line rises, and the waveform holds a programmable offset level while the controller auto-zeroes. It then steps to a start level that closes the control loop. It rises to the maximum level along a raised-cosine edge and holds that level for the burst. It falls back to zero along a second raised-cosine edge and waits at zero long enough for the amplifier to switch off. Finally it drops the enable line and pulses done.

All durations are counted in ticks of a timebase. The timebase comes from the system clock through a programmable divider, and one tick is nominally 0.5 µs. Eight burst profiles arrive on a flat bank input from external storage. A selector picks one profile, and the sequencer copies it into its own registers when a burst starts.

Top module: `burst_ramp_seq`

## Requirements
- R1: When `trig_i` is sampled high while idle, `en_o` goes high on the next clock, the profile picked by `sel_i` is captured, and `code_o` shows that profile's offset level. `en_o` stays high until the burst ends.
- R2: The offset level is held for exactly OFS_TICKS ticks (default 24, which is 12 µs).
- R3: The step level is then held for `step_t` ticks.
- R4: During the rise, `code_o` = step + floor((max − step)·w[i]/4096), within ±1 code. Here i = floor(c·64/`rise_t`), c is the number of ticks elapsed in the rise, and w[i] = round(4096·sin²(π·i/128)). The rise lasts `rise_t` ticks and `code_o` never leaves the range between the two levels.
- R5: The maximum level is then held for `max_t` ticks.
- R6: During the fall, `code_o` follows the same formula from the maximum level down to 0 over `fall_t` ticks, within ±1 code.
- R7: `code_o` is then 0 with `en_o` still high for `zero_t` ticks, after which `en_o` goes low.
- R8: One tick is `div_i`+1 clocks, and the first tick of a burst completes `div_i`+1 clocks after the trigger edge. A duration field of 0 lasts one tick.
- R9: A trigger that arrives while `en_o` is high has no effect on the waveform or its timing.
- R10: Changes to `sel_i` or `bank_i` during a burst have no effect until the next trigger. Profile k occupies `bank_i[k*90 +: 90]`. From the MSB down, its fields are: offset level, step level and max level (10 bits each), then `step_t`, `rise_t`, `max_t`, `fall_t` and `zero_t` (12 bits each).
- R11: `done_o` is high for exactly one clock, in the same cycle in which `en_o` first reads low after a burst.
- R12: During and after reset, `en_o` = 0, `done_o` = 0 and `code_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start-of-burst trigger |
| sel_i | input | 3 | Profile selector |
| div_i | input | 8 | Timebase divider; tick = div_i+1 clocks |
| bank_i | input | 720 | Eight packed profiles |
| code_o | output | 10 | DAC code |
| en_o | output | 1 | Power controller enable (high = active) |
| done_o | output | 1 | One-clock pulse at return to idle |

## Verification
Every clock of each burst is compared with a model built from the requirements. An off-by-one phase counter therefore shows up as a level that starts one tick early or late. A wrong table index or a wrong sign on the fall would push the edge codes past the ±1 code band. Zero-length fields and a divider of 0 are exercised, because a sequencer that treats 0 as 4096 would hang at that phase. Triggers and profile or selector changes are injected in the middle of a burst. A design that restarts on the second trigger, or reads the bank live instead of from its captured copy, would move or reshape the waveform.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CODE_W = 10;
  localparam int TICK_W = 12;
  localparam int LUT_N  = 64;
  localparam int WQ     = 12;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OFS, PH_STEP, PH_RISE, PH_MAX, PH_FALL, PH_ZERO
  } phase_e;

  typedef struct packed {
    logic [CODE_W-1:0] off_lvl;
    logic [CODE_W-1:0] step_lvl;
    logic [CODE_W-1:0] max_lvl;
    logic [TICK_W-1:0] step_t;
    logic [TICK_W-1:0] rise_t;
    logic [TICK_W-1:0] max_t;
    logic [TICK_W-1:0] fall_t;
    logic [TICK_W-1:0] zero_t;
  } prof_t;

  localparam int PROF_W = $bits(prof_t);
endpackage

// File: rtl/brs_tick_gen.sv
module brs_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q;

  assign tick_o = (pc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (clr_i || tick_o)   pc_q <= '0;
    else                        pc_q <= pc_q + 1'b1;
  end

  assert_tick_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/brs_cos_lut.sv
module brs_cos_lut #(
  parameter int LUT_N = 64,
  parameter int WQ    = 12,
  localparam int IDX_W = $clog2(LUT_N)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [WQ:0]      w_o
);
  // sin^2(pi*i/(2N)) in fixed point, Taylor series on a Q20 angle
  function automatic longint sin2_fx(int i);
    longint one, x, term, s, half;
    one  = longint'(1) << 20;
    x    = (longint'(3294199) * i) / (2 * LUT_N);
    term = x;
    s    = x;
    for (int k = 1; k <= 7; k++) begin
      term = -(((term * x) / one) * x / one) / (2 * k * (2 * k + 1));
      s    = s + term;
    end
    half = longint'(1) << (39 - WQ);
    return (s * s + half) >>> (40 - WQ);
  endfunction

  logic [WQ:0] tbl [LUT_N];

  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_tbl
    localparam longint VAL = sin2_fx(gi);
    assign tbl[gi] = (WQ+1)'(VAL);
  end

  assign w_o = tbl[idx_i];
endmodule

// File: rtl/brs_edge_interp.sv
module brs_edge_interp #(
  parameter int CODE_W = 10,
  parameter int TICK_W = 12,
  parameter int LUT_N  = 64,
  parameter int WQ     = 12
) (
  input  logic [CODE_W-1:0] from_i,
  input  logic [CODE_W-1:0] to_i,
  input  logic [TICK_W-1:0] cnt_i,
  input  logic [TICK_W-1:0] len_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int IDX_W = $clog2(LUT_N);
  localparam int NUM_W = TICK_W + IDX_W;
  localparam int PR_W  = CODE_W + WQ + 2;

  logic [NUM_W-1:0] num, quo;
  logic [IDX_W-1:0] idx;
  logic [WQ:0]      w;
  logic signed [CODE_W:0] delta;
  logic signed [PR_W-1:0] prod, sum;

  assign num = {cnt_i, {IDX_W{1'b0}}};
  assign quo = (len_i == '0) ? '0 : num / {{IDX_W{1'b0}}, len_i};
  assign idx = (quo > NUM_W'(LUT_N - 1)) ? IDX_W'(LUT_N - 1) : quo[IDX_W-1:0];

  brs_cos_lut #(.LUT_N(LUT_N), .WQ(WQ)) u_lut (.idx_i(idx), .w_o(w));

  assign delta = $signed({1'b0, to_i}) - $signed({1'b0, from_i});
  assign prod  = delta * $signed({1'b0, w});
  assign sum   = $signed({{(WQ+2){1'b0}}, from_i}) + (prod >>> WQ);

  always_comb begin
    if (sum < 0)                                   code_o = '0;
    else if (sum > $signed(PR_W'({CODE_W{1'b1}}))) code_o = '1;
    else                                           code_o = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq
  import brs_pkg::*;
#(
  parameter int NPROF     = 8,
  parameter int PRE_W     = 8,
  parameter int OFS_TICKS = 24,
  localparam int SEL_W    = $clog2(NPROF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    trig_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [PRE_W-1:0]        div_i,
  input  logic [NPROF*PROF_W-1:0] bank_i,
  output logic [CODE_W-1:0]       code_o,
  output logic                    en_o,
  output logic                    done_o
);
  phase_e            phase_q;
  logic [TICK_W-1:0] cnt_q, len;
  logic [TICK_W:0]   cnt_p1;
  prof_t             prof_q;
  logic              done_q, tick, start, last;
  logic [CODE_W-1:0] e_from, e_to, e_code;

  assign start = (phase_q == PH_IDLE) && trig_i;

  brs_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start), .div_i(div_i), .tick_o(tick));

  always_comb begin
    case (phase_q)
      PH_OFS:  len = TICK_W'(OFS_TICKS);
      PH_STEP: len = prof_q.step_t;
      PH_RISE: len = prof_q.rise_t;
      PH_MAX:  len = prof_q.max_t;
      PH_FALL: len = prof_q.fall_t;
      PH_ZERO: len = prof_q.zero_t;
      default: len = '0;
    endcase
  end

  assign cnt_p1 = {1'b0, cnt_q} + 1'b1;
  assign last   = tick && (cnt_p1 >= {1'b0, len});  // zero length acts as one tick

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      prof_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        phase_q <= PH_OFS;
        cnt_q   <= '0;
        prof_q  <= bank_i[sel_i*PROF_W +: PROF_W];
      end else if (phase_q != PH_IDLE && tick) begin
        if (last) begin
          cnt_q <= '0;
          if (phase_q == PH_ZERO) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= phase_e'(phase_q + 3'd1);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign e_from = (phase_q == PH_FALL) ? prof_q.max_lvl : prof_q.step_lvl;
  assign e_to   = (phase_q == PH_FALL) ? '0 : prof_q.max_lvl;

  brs_edge_interp #(.CODE_W(CODE_W), .TICK_W(TICK_W), .LUT_N(LUT_N), .WQ(WQ)) u_edge (
    .from_i(e_from), .to_i(e_to), .cnt_i(cnt_q), .len_i(len), .code_o(e_code));

  always_comb begin
    case (phase_q)
      PH_OFS:           code_o = prof_q.off_lvl;
      PH_STEP:          code_o = prof_q.step_lvl;
      PH_RISE, PH_FALL: code_o = e_code;
      PH_MAX:           code_o = prof_q.max_lvl;
      default:          code_o = '0;
    endcase
  end

  assign en_o   = (phase_q != PH_IDLE);
  assign done_o = done_q;

  assert_en_onset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> ($past(trig_i) && code_o == prof_q.off_lvl));

  assert_ofs_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STEP && $past(phase_q) == PH_OFS) |-> ($past(cnt_q) == TICK_W'(OFS_TICKS - 1)));

  assert_rise_bounds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RISE) |->
      ((code_o >= prof_q.step_lvl && code_o <= prof_q.max_lvl) ||
       (code_o <= prof_q.step_lvl && code_o >= prof_q.max_lvl)));

  assert_fall_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FALL) |-> (code_o <= prof_q.max_lvl));

  assert_profile_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> $stable(prof_q));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!en_o && $past(en_o)) ##1 !done_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> (code_o == '0));
endmodule

// File: tb/sim_burst_ramp_seq.sv
module sim_burst_ramp_seq;
  import brs_pkg::*;

  localparam int NPROF = 8;
  localparam int OFS   = 24;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] div = '0;
  logic [NPROF*PROF_W-1:0] bank;
  logic [CODE_W-1:0] code;
  logic en, done;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  burst_ramp_seq u0 (.clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .sel_i(sel),
    .div_i(div), .bank_i(bank), .code_o(code), .en_o(en), .done_o(done));

  function automatic prof_t mk(int k);
    prof_t p;
    p.off_lvl  = 10'(50 + 10 * k);
    p.step_lvl = 10'(70 + 12 * k);
    p.max_lvl  = 10'(500 + 60 * k);
    p.step_t   = 12'(2 + k);
    p.rise_t   = 12'(12 + 3 * k);
    p.max_t    = 12'(10 + k);
    p.fall_t   = 12'(14 + 4 * k);
    p.zero_t   = 12'(2);
    return p;
  endfunction

  function automatic int wt(int i);
    real s;
    s = $sin(3.14159265358979 * i / 128.0);
    return int'(4096.0 * s * s);
  endfunction

  function automatic int edge_code(int a, int b, int c, int len);
    int idx;
    idx = (len == 0) ? 0 : (c * 64) / len;
    if (idx > 63) idx = 63;
    return a + int'($floor(real'((b - a) * wt(idx)) / 4096.0));
  endfunction

  function automatic int dur(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic model(input prof_t p, input int dv, input int t, output int ec,
                       output bit een, output bit edn, output int tol, output string tag);
    int d[6];
    int m, acc, total;
    d[0] = OFS; d[1] = dur(p.step_t); d[2] = dur(p.rise_t);
    d[3] = dur(p.max_t); d[4] = dur(p.fall_t); d[5] = dur(p.zero_t);
    total = 0;
    foreach (d[k]) total += d[k];
    m = t / (dv + 1);
    ec = 0; een = 1'b0; edn = 1'b0; tol = 0; tag = "R11";
    if (m >= total) begin
      edn = (t == total * (dv + 1));
      return;
    end
    een = 1'b1;
    acc = 0;
    for (int k = 0; k < 6; k++) begin
      if (m < acc + d[k]) begin
        case (k)
          0: begin ec = p.off_lvl;  tag = (t == 0) ? "R1" : "R2"; end
          1: begin ec = p.step_lvl; tag = "R3"; end
          2: begin ec = edge_code(p.step_lvl, p.max_lvl, m - acc, p.rise_t); tol = 1; tag = "R4"; end
          3: begin ec = p.max_lvl;  tag = "R5"; end
          4: begin ec = edge_code(p.max_lvl, 0, m - acc, p.fall_t); tol = 1; tag = "R6"; end
          default: begin ec = 0;    tag = "R7"; end
        endcase
        return;
      end
      acc += d[k];
    end
  endtask

  function automatic int burst_len(prof_t p, int dv);
    return (OFS + dur(p.step_t) + dur(p.rise_t) + dur(p.max_t) + dur(p.fall_t) +
            dur(p.zero_t)) * (dv + 1);
  endfunction

  // retrig_at / swap_at < 0 disables the injection
  task automatic run_burst(input int s, input int dv, input string ctx,
                           input int retrig_at, input int swap_at);
    prof_t p;
    int ec, tol, tlast, diff;
    bit een, edn;
    string tag;
    p = bank[s*PROF_W +: PROF_W];
    div = 8'(dv);
    @(negedge clk); sel = 3'(s); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    tlast = burst_len(p, dv) + 2;
    for (int t = 0; t <= tlast; t++) begin
      model(p, dv, t, ec, een, edn, tol, tag);
      diff = int'(code) - ec;
      n_chk++;
      if (diff > tol || diff < -tol || en !== een || done !== edn) begin
        n_fail++;
        $display("FAIL %s %s t=%0d actual code=%0d en=%0b done=%0b expected code=%0d en=%0b done=%0b",
                 tag, ctx, t, code, en, done, ec, een, edn);
      end
      trig = (t == retrig_at || t == retrig_at + 37);
      if (t == swap_at) begin
        sel = 3'(s ^ 3'd4);
        bank[s*PROF_W +: PROF_W] = mk(7);
      end
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  task automatic t_reset();
    n_chk++;
    if (en !== 1'b0 || done !== 1'b0 || code !== '0) begin
      n_fail++;
      $display("FAIL R12 reset actual en=%0b done=%0b code=%0d expected 0 0 0", en, done, code);
    end
  endtask

  task automatic t_nominal();        // R1..R7, R11
    run_burst(0, 1, "nominal", -1, -1);
  endtask

  task automatic t_zero_fields();    // R8: zero-length fields, divider 0
    prof_t p;
    p = mk(3);
    p.step_t = '0; p.zero_t = '0; p.max_lvl = 10'd1023;
    bank[3*PROF_W +: PROF_W] = p;
    run_burst(3, 0, "R8 zero-fields", -1, -1);
  endtask

  task automatic t_retrigger();      // R9
    prof_t p;
    p = mk(5);
    p.rise_t = 12'd70;               // longer than the table
    bank[5*PROF_W +: PROF_W] = p;
    run_burst(5, 2, "R9 retrigger", 40, -1);
  endtask

  task automatic t_sel_change();     // R10
    prof_t keep;
    keep = bank[2*PROF_W +: PROF_W];
    run_burst(2, 1, "R10 sel/bank change", -1, 10);
    bank[2*PROF_W +: PROF_W] = keep;
    run_burst(2, 1, "R10 next burst", -1, -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPROF; k++) bank[k*PROF_W +: PROF_W] = mk(k);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_zero_fields();
    t_retrigger();
    t_sel_change();
    repeat (3) @(negedge clk);
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule